// File: doc/BRIEF.md
# Radix-4 SRT Significand Divider

This block divides one normalized significand by another, producing two quotient bits per clock. Both operands are unsigned fixed-point values in [1,2) with the binary point just below the top bit. On each iteration it picks one signed quotient digit from the set -2, -1, 0, +1, +2 by looking at a short truncated view of the shifted partial remainder and of the divisor. It then subtracts that digit times the divisor from the shifted remainder.

The digit set is redundant, so a digit that comes out one step too large or too small is absorbed by the digits that follow, including negative ones. The loop therefore needs no full-width compare and no restore step. Positive and negative digits build up in two separate registers. Once the last iteration is done, their difference becomes the binary quotient. If the final remainder is negative, the quotient is reduced by one and the divisor is added back. The result is an exact truncated quotient, a non-negative remainder and a sticky flag, ready for a rounding stage further down the pipe. Exponent logic and rounding are not part of this block.

Top module: `srt_div4`

## Requirements
- R1: Every iteration retires exactly one digit. The digit is held as a sign bit plus a magnitude in 0..2, and a negative zero is never produced. With the default SIG_W=24 there are ITER=(SIG_W+3)/2=13 iterations, so the quotient has QW=2*ITER=26 bits.
- R2: Digit selection reads the top 7 bits of the shifted partial remainder and the top 4 bits of the divisor. The remainder bits are two's complement, 4 integer bits and 3 fraction bits. The divisor bits are 1.xxx. All eight divisor columns, 1.000 through 1.111, give exact results, including divisors just on either side of each column edge.
- R3: After every iteration the partial remainder w satisfies |w| <= (2/3)*divisor. It is stored in two's complement with a 4-bit integer part, which covers the shifted range of +-(8/3)*divisor.
- R4: With dividend A and divisor D taken as SIG_W-bit integers, quot_o equals floor(A * 2^(2*ITER-2) / D).
- R5: rem_o equals A * 2^(2*ITER-2) - quot_o * D and lies in [0, D). A negative final partial remainder is corrected by adding D back and reducing the quotient by one.
- R6: sticky_o is 1 exactly when rem_o is non-zero.
- R7: start_i is accepted while busy_o is 0. busy_o then stays 1 until the result is written. done_o is a one-cycle pulse that rises ITER+1 clock edges after the edge that accepted start_i, and the new results appear in that same cycle.
- R8: A start_i pulse while busy_o is 1 is ignored. The division in progress completes with its original operands and its original latency.
- R9: quot_o, rem_o and sticky_o change only in a cycle where done_o is 1, and they hold their values until the next result.
- R10: While reset is held, busy_o, done_o, quot_o, rem_o and sticky_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a division with the operands present this cycle |
| dividend_i | input | SIG_W | Normalized dividend, top bit set |
| divisor_i | input | SIG_W | Normalized divisor, top bit set |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse when results are written |
| quot_o | output | QW | Binary quotient, truncated |
| rem_o | output | SIG_W | Corrected non-negative remainder |
| sticky_o | output | 1 | Remainder is non-zero |

## Verification
The bench builds the block at SIG_W=24, which gives 13 iterations and a 26-bit quotient. At this width the exact reference A*2^24/D fits easily in 64-bit bench arithmetic, so every quotient and remainder bit is compared. Divisors are placed on both sides of each of the eight 1.xxx selection columns, with the five edges 1.0001, 1.0100, 1.0111, 1.1010 and 1.1101 among them. Dividends are driven to their extremes to push the estimate into the corners of the selection function. Random operands fill in the interior, and a start pulse in the middle of a run checks that a busy divider ignores it.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;

    // Truncated views used by the digit selection
    localparam int EST_W     = 7;   // shifted remainder estimate: 4 int + 3 frac
    localparam int DEST_W    = 4;   // divisor estimate: 1.xxx
    localparam int INT_W     = 4;   // integer bits of the partial remainder (incl. sign)

    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } qdig_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } srt_state_e;

    // ceil(p/3) for signed p
    function automatic int ceil_third(input int p);
        if (p >= 0) return (p + 2) / 3;
        else        return -((-p) / 3);
    endfunction

    // Digit selection. Thresholds are in units of 1/8 and are derived
    // from the overlap of neighbouring digit intervals over the whole
    // divisor column [dlo, dlo + 1/8). The estimate truncates toward
    // minus infinity, so the true value lies in [est, est + 1/8).
    function automatic qdig_t sel_digit(input logic signed [EST_W-1:0] est,
                                        input logic [DEST_W-1:0]       dcol);
        int    y;
        int    dlo;
        int    dhi;
        int    m_p2;
        int    m_p1;
        int    m_z;
        int    m_n1;
        qdig_t d;
        y    = int'(est);
        dlo  = 8 + int'(dcol[DEST_W-2:0]);
        dhi  = dlo + 1;
        m_p2 = ceil_third(4 * dhi);
        m_p1 = ceil_third(dhi);
        m_z  = ceil_third(-2 * dlo);
        m_n1 = ceil_third(-5 * dlo);
        if (!dcol[DEST_W-1])  d = '{neg: 1'b0, mag: 2'd0}; // not normalized: unreachable
        else if (y >= m_p2)   d = '{neg: 1'b0, mag: 2'd2};
        else if (y >= m_p1)   d = '{neg: 1'b0, mag: 2'd1};
        else if (y >= m_z)    d = '{neg: 1'b0, mag: 2'd0};
        else if (y >= m_n1)   d = '{neg: 1'b1, mag: 2'd1};
        else                  d = '{neg: 1'b1, mag: 2'd2};
        return d;
    endfunction

endpackage

// File: rtl/srt_qsel.sv
module srt_qsel
    import srt_div_pkg::*;
#(
    parameter int SIG_W = 24,
    localparam int RW   = SIG_W + 1 + INT_W
) (
    input  logic [RW-1:0]    rem_sh,
    input  logic [SIG_W-1:0] dvs,
    output qdig_t            dig
);
    logic signed [EST_W-1:0] est;
    logic [DEST_W-1:0]       dcol;

    assign est  = rem_sh[RW-1 -: EST_W];
    assign dcol = dvs[SIG_W-1 -: DEST_W];

    always_comb dig = sel_digit(est, dcol);

endmodule

// File: rtl/srt_rem_path.sv
module srt_rem_path
    import srt_div_pkg::*;
#(
    parameter int SIG_W = 24,
    localparam int FRAC = SIG_W + 1,
    localparam int RW   = FRAC + INT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             fix,
    input  logic [SIG_W-1:0] dividend,
    input  logic [SIG_W-1:0] divisor,
    output qdig_t            dig,
    output logic             rem_neg,
    output logic [SIG_W-1:0] rem_corr
);
    logic [RW-1:0]    w_q;
    logic [SIG_W-1:0] dvs_q;
    logic [RW-1:0]    dw;
    logic [RW-1:0]    w_sh;
    logic [RW-1:0]    mult;
    logic [RW-1:0]    w_nxt;
    logic [RW-1:0]    w_fix;

    // divisor aligned to the remainder's binary point
    assign dw   = {3'b000, dvs_q, 2'b00};
    assign w_sh = {w_q[RW-3:0], 2'b00};

    srt_qsel #(.SIG_W(SIG_W)) u_qsel (
        .rem_sh (w_sh),
        .dvs    (dvs_q),
        .dig    (dig)
    );

    always_comb begin
        unique case (dig.mag)
            2'd2:    mult = {dw[RW-2:0], 1'b0};
            2'd1:    mult = dw;
            default: mult = '0;
        endcase
        w_nxt = dig.neg ? (w_sh + mult) : (w_sh - mult);
    end

    assign rem_neg  = w_q[RW-1];
    assign w_fix    = rem_neg ? (w_q + dw) : w_q;
    assign rem_corr = w_fix[SIG_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q   <= '0;
            dvs_q <= '0;
        end else if (load) begin
            w_q   <= {{INT_W{1'b0}}, 1'b0, dividend};
            dvs_q <= divisor;
        end else if (step) begin
            w_q   <= w_nxt;
        end
    end

    // ---- checks ----
    logic          stepped_q;
    logic [RW-1:0] w_abs;
    logic [RW+1:0] lhs3;
    logic [RW+1:0] rhs2;

    always_ff @(posedge clk) begin
        if (rst) stepped_q <= 1'b0;
        else     stepped_q <= step;
    end

    assign w_abs = w_q[RW-1] ? (~w_q + 1'b1) : w_q;
    assign lhs3  = {2'b00, w_abs} + {1'b0, w_abs, 1'b0};
    assign rhs2  = {1'b0, dw, 1'b0};

    // R3: remainder stays inside (2/3)*divisor after every iteration
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
        stepped_q |-> (lhs3 <= rhs2));

    // R5: corrected remainder is non-negative and below the divisor
    p_fix_range_r5: assert property (@(posedge clk) disable iff (rst)
        fix |-> (!w_fix[RW-1] && (w_fix < dw)));

endmodule

// File: rtl/srt_qacc.sv
module srt_qacc
    import srt_div_pkg::*;
#(
    parameter int QW = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  qdig_t         dig,
    input  logic          rem_neg,
    output logic [QW-1:0] quot
);
    logic [QW-1:0] qpos_q;
    logic [QW-1:0] qneg_q;
    logic [1:0]    pos_mag;
    logic [1:0]    neg_mag;

    assign pos_mag = dig.neg ? 2'd0 : dig.mag;
    assign neg_mag = dig.neg ? dig.mag : 2'd0;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            qpos_q <= '0;
            qneg_q <= '0;
        end else if (step) begin
            qpos_q <= {qpos_q[QW-3:0], pos_mag};
            qneg_q <= {qneg_q[QW-3:0], neg_mag};
        end
    end

    assign quot = qpos_q - qneg_q - {{(QW-1){1'b0}}, rem_neg};

    // R1: each retired digit is one of -2..+2 with no negative zero
    p_digit_legal_r1: assert property (@(posedge clk) disable iff (rst)
        step |-> ((dig.mag != 2'd3) && !(dig.neg && (dig.mag == 2'd0))));

endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl
    import srt_div_pkg::*;
#(
    parameter int ITER = 13,
    localparam int CW  = $clog2(ITER + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);
    srt_state_e     state_q;
    logic [CW-1:0]  cnt_q;

    assign load = start && (state_q == ST_IDLE);
    assign step = (state_q == ST_RUN);
    assign fix  = (state_q == ST_FIX);
    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(ITER - 1)) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a start seen while running does not leave the run state
    p_run_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (step && start && (cnt_q != CW'(ITER - 1))) |=> step);

endmodule

// File: rtl/srt_div4.sv
module srt_div4
    import srt_div_pkg::*;
#(
    parameter int  SIG_W = 24,
    localparam int ITER  = (SIG_W + 3) / 2,
    localparam int QW    = 2 * ITER
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [SIG_W-1:0] dividend_i,
    input  logic [SIG_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [QW-1:0]    quot_o,
    output logic [SIG_W-1:0] rem_o,
    output logic             sticky_o
);
    logic             load;
    logic             step;
    logic             fix;
    qdig_t            dig;
    logic             rem_neg;
    logic [SIG_W-1:0] rem_corr;
    logic [QW-1:0]    quot_raw;

    srt_ctrl #(.ITER(ITER)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy_o),
        .done  (done_o)
    );

    srt_rem_path #(.SIG_W(SIG_W)) u_rem (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .fix      (fix),
        .dividend (dividend_i),
        .divisor  (divisor_i),
        .dig      (dig),
        .rem_neg  (rem_neg),
        .rem_corr (rem_corr)
    );

    srt_qacc #(.QW(QW)) u_qacc (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step),
        .dig     (dig),
        .rem_neg (rem_neg),
        .quot    (quot_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            quot_o   <= '0;
            rem_o    <= '0;
            sticky_o <= 1'b0;
        end else if (fix) begin
            quot_o   <= quot_raw;
            rem_o    <= rem_corr;
            sticky_o <= |rem_corr;
        end
    end

    // ---- checks ----
    localparam int LW = $clog2(ITER + 3);
    logic [LW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)                           lat_q <= '0;
        else if (load)                     lat_q <= '0;
        else if (lat_q != LW'(ITER + 2))   lat_q <= lat_q + 1'b1;
    end

    // R1: one digit per cycle gives a fixed ITER+1 latency to done
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_q == LW'(ITER + 1)));

    // R9: results hold between done pulses
    p_hold_quot_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(sticky_o)));

endmodule

// File: tb/srt_div4_tb.sv
`timescale 1ns/1ps
module srt_div4_tb;
    localparam int SIG_W = 24;
    localparam int ITER  = (SIG_W + 3) / 2;
    localparam int QW    = 2 * ITER;
    localparam int SH    = 2 * ITER - 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [SIG_W-1:0] dividend_i = '0;
    logic [SIG_W-1:0] divisor_i  = '0;
    logic             busy_o;
    logic             done_o;
    logic [QW-1:0]    quot_o;
    logic [SIG_W-1:0] rem_o;
    logic             sticky_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    srt_div4 #(.SIG_W(SIG_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .quot_o     (quot_o),
        .rem_o      (rem_o),
        .sticky_o   (sticky_o)
    );

    function automatic logic [63:0] ref_q(input logic [SIG_W-1:0] a, input logic [SIG_W-1:0] d);
        return (64'(a) << SH) / 64'(d);
    endfunction

    function automatic logic [63:0] ref_r(input logic [SIG_W-1:0] a, input logic [SIG_W-1:0] d);
        return (64'(a) << SH) % 64'(d);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // poke: fire a second start in the middle of the run (R8)
    task automatic do_div(input logic [SIG_W-1:0] a, input logic [SIG_W-1:0] d,
                          input string tag, input bit poke);
        int lat;
        @(negedge clk);
        start_i = 1'b1; dividend_i = a; divisor_i = d;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R7 busy after start"}, 64'(busy_o), 64'd1);
        lat = 0;
        while (!done_o && lat < 60) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 4) begin
                start_i = 1'b1; dividend_i = ~a | 24'h800000; divisor_i = 24'hC00001;
            end else begin
                start_i = 1'b0; dividend_i = a; divisor_i = d;
            end
        end
        start_i = 1'b0;
        chk({tag, " R1 latency"}, 64'(lat), 64'(ITER + 1));
        chk({tag, " R4 quotient"}, 64'(quot_o), ref_q(a, d));
        chk({tag, " R5 remainder"}, 64'(rem_o), ref_r(a, d));
        chk({tag, " R6 sticky"}, 64'(sticky_o), 64'(ref_r(a, d) != 0));
        @(negedge clk);
        chk({tag, " R7 done pulse ends"}, 64'(done_o), 64'd0);
        chk({tag, " R7 idle after done"}, 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [SIG_W-1:0] a;
        logic [SIG_W-1:0] d;
        logic [4:0]       edge_pat [5];
        void'($urandom(32'd20231));

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 busy", 64'(busy_o), 64'd0);
        chk("R10 done", 64'(done_o), 64'd0);
        chk("R10 quot", 64'(quot_o), 64'd0);
        chk("R10 rem", 64'(rem_o), 64'd0);
        chk("R10 sticky", 64'(sticky_o), 64'd0);
        rst = 1'b0;

        // directed: small exact cases
        do_div(24'h800000, 24'h800000, "one", 1'b0);
        do_div(24'hFFFFFF, 24'h800000, "max/1", 1'b0);
        do_div(24'h800000, 24'hFFFFFF, "1/max", 1'b0);
        do_div(24'hE00000, 24'hC00000, "7/6", 1'b0);

        // R2: every divisor column, both sides of each edge
        for (int c = 0; c < 8; c++) begin
            d = {1'b1, 3'(c), 20'h00000};
            do_div(24'hFFFFFF, d, "R2 col low", 1'b0);
            do_div(24'h800000, d, "R2 col low min", 1'b0);
            d = {1'b1, 3'(c), 20'hFFFFF};
            do_div(24'hFFFFFF, d, "R2 col high", 1'b0);
            do_div(24'hBFFFFF, d, "R2 col high mid", 1'b0);
        end

        // R2: the five edge divisors just below and at each edge
        edge_pat[0] = 5'b10001; edge_pat[1] = 5'b10100; edge_pat[2] = 5'b10111;
        edge_pat[3] = 5'b11010; edge_pat[4] = 5'b11101;
        for (int e = 0; e < 5; e++) begin
            d = {edge_pat[e], 19'h7FFFF};
            do_div(24'hBFFFFF, d, "R2 edge ones", 1'b0);
            do_div(24'hFFFFFE, d, "R2 edge ones hi", 1'b0);
            d = {edge_pat[e], 19'h00000};
            do_div(24'hFFFFFF, d, "R2 edge zeros", 1'b0);
            for (int k = 0; k < 6; k++) begin
                a = {1'b1, 23'($urandom)};
                d = {edge_pat[e], 19'h7FF00 | 19'($urandom & 32'hFF)};
                do_div(a, d, "R2 edge random", 1'b0);
            end
        end

        // R8: start while busy is ignored
        do_div(24'hABCDEF, 24'h9ABCDE, "R8 poke", 1'b1);
        do_div(24'h800001, 24'hFFFFFE, "R8 poke2", 1'b1);

        // R9: outputs hold while inputs move and no start is given
        repeat (3) begin
            @(negedge clk);
            dividend_i = 24'($urandom) | 24'h800000;
            divisor_i  = 24'($urandom) | 24'h800000;
        end
        chk("R9 quot holds", 64'(quot_o), ref_q(24'h800001, 24'hFFFFFE));
        chk("R9 rem holds", 64'(rem_o), ref_r(24'h800001, 24'hFFFFFE));

        // R3/R4: random interior operands
        for (int i = 0; i < 250; i++) begin
            a = {1'b1, 23'($urandom)};
            d = {1'b1, 23'($urandom)};
            do_div(a, d, "R3 random", 1'b0);
        end

        report();
    end
endmodule